// File: doc/BRIEF.md
# Amplitude to Decibel Converter

This block turns an unsigned linear amplitude, for example the magnitude produced by a CORDIC vectoring stage, into a level in decibels equal to 20·log10 of the input. It is a streaming pipeline. A sample is presented with a valid strobe, and the converted value appears a fixed number of cycles later with its own strobe. The block accepts a new sample on every clock.

The conversion is done in the base-2 domain. A leading-one search gives the integer part of log2 and normalises the amplitude to the form 1.xxx. The bits just below the leading one address a short table that holds the fractional part of log2. The table is filled at elaboration by a constant function. The complete log2 value is then multiplied by a fixed-point copy of 20·log10(2), about 6.0206, and rounded to the nearest 1/16 dB.

A zero amplitude has no logarithm. For that sample the block drives the output to 0 and raises a flag.

Top module: `mag2db`

## Requirements
- R1: For every nonzero input x from 1 to 2^24−1, `out_db` is an unsigned 8.4 fixed-point value (bits 11:4 are whole dB, bits 3:0 are sixteenths of a dB). It lies within ±1 LSB of 16·20·log10(x) computed in real arithmetic.
- R2: An input of 1 produces `out_db` = 0.
- R3: An input of 2^23 produces `out_db` of 2215 or 2216 (ideal 138.47 dB, which is 2215.6 LSB).
- R4: An input of 0 produces `out_db` = 0 with `out_zero` = 1. Any nonzero input produces `out_zero` = 0.
- R5: `out_valid` is asserted exactly three clock cycles after `in_valid` is sampled high. Back-to-back samples are accepted on every clock with no stall.
- R6: While `out_valid` is low, `out_db` and `out_zero` hold the values of the last converted sample.
- R7: The full-scale input 2^24−1 produces a value no larger than 2312 (144.5 dB) and within ±1 LSB of the ideal.
- R8: While `rst_n` is low, and in the cycles after reset before any sample has passed through, `out_valid`, `out_db` and `out_zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_mag` in this cycle |
| in_mag | input | 24 | Unsigned linear amplitude |
| out_valid | output | 1 | Qualifies `out_db` and `out_zero` |
| out_db | output | 12 | Level in dB, unsigned, 4 fractional bits |
| out_zero | output | 1 | High when the converted sample was zero |

## Verification
The bench builds the block with its default parameters:
- a 24-bit input;
- an 8-bit table address, which gives 256 entries;
- 12 fractional bits in each table entry;
- 16 fractional bits in the scaling constant.

With these values every leading-one position from bit 0 to bit 23 can be reached, as can every table index. This covers powers of two, values one either side of them, full scale, and a pseudo-random sweep spread over the whole dynamic range. The end-to-end error against real arithmetic is checked on every output sample. Gaps in the valid stream test the fixed latency and the hold behaviour.

// File: rtl/mag2db_pkg.sv
// Package: shared constant functions for the amplitude-to-decibel pipeline.
// Assumes: callers pass small elaboration-time constants only.
package mag2db_pkg;

    // Fractional log2 of the bin midpoint (1 + (idx+0.5)/2^abits), rounded to fbits.
    // Uses repeated squaring in Q30 integer arithmetic so no real math is needed.
    function automatic int unsigned frac_log2_mid(input int unsigned idx,
                                                  input int unsigned abits,
                                                  input int unsigned fbits);
        longint unsigned x;
        longint unsigned acc;
        x = (longint'(64'd1) << (abits + 1)) + longint'(2 * idx + 1);
        x = x << (30 - abits - 1);
        acc = 0;
        for (int unsigned b = 0; b < fbits + 1; b++) begin
            x   = (x * x) >> 30;
            acc = acc << 1;
            if (x >= (longint'(64'd2) << 30)) begin
                acc = acc | 64'd1;
                x   = x >> 1;
            end
        end
        return int'((acc + 64'd1) >> 1);
    endfunction

    // 20*log10(2) as an unsigned fixed-point integer with fbits fraction bits.
    function automatic longint unsigned db_per_octave(input int unsigned fbits);
        real scaled;
        scaled = 6.020599913279624 * (2.0 ** fbits) + 0.5;
        return longint'($rtoi(scaled));
    endfunction

endpackage

// File: rtl/mag2db_lod.sv
// Module: leading-one detector and normaliser.
// Finds the highest set bit of the amplitude (the integer part of log2) and
// returns the ABITS bits directly below it once it is shifted to the top.
// Assumes IN_W > ABITS. For a zero input, zero=1 and the other outputs are 0.
module mag2db_lod #(
    parameter int IN_W  = 24,
    parameter int ABITS = 8,
    localparam int POS_W = $clog2(IN_W)
) (
    input  logic [IN_W-1:0]  mag,
    output logic [POS_W-1:0] pos,
    output logic [ABITS-1:0] idx,
    output logic             zero
);
    logic [IN_W-1:0] norm;
    logic            found;

    // Scan upward so the highest set bit wins.
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = 0; i < IN_W; i++) begin
            if (mag[i]) begin
                pos   = POS_W'(i);
                found = 1'b1;
            end
        end
    end

    // Shift the leading one up to the MSB and take the bits under it.
    always_comb begin
        norm = mag << (POS_W'(IN_W - 1) - pos);
        idx  = norm[IN_W-2 -: ABITS];
        zero = ~found;
    end
endmodule

// File: rtl/mag2db_frac_rom.sv
// Module: fractional-log2 table, 2^ABITS entries of FBITS bits, read combinationally.
// Each entry holds log2 at the midpoint of its bin, which halves the error
// from dropping the bits below the address. Contents are built at elaboration.
module mag2db_frac_rom #(
    parameter int ABITS = 8,
    parameter int FBITS = 12,
    localparam int DEPTH = 1 << ABITS
) (
    input  logic [ABITS-1:0] addr,
    output logic [FBITS-1:0] frac
);
    logic [FBITS-1:0] table_q [DEPTH];

    // One constant entry per address.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        assign table_q[gi] = FBITS'(mag2db_pkg::frac_log2_mid(gi, ABITS, FBITS));
    end

    // Table read.
    assign frac = table_q[addr];
endmodule

// File: rtl/mag2db_scale.sv
// Module: base-change multiply and round to the output grid.
// Multiplies log2 (integer.fraction, LOG_FB fraction bits) by 20*log10(2)
// (K_FB fraction bits) and rounds half-up to OUT_FB fraction bits.
// Assumes the result fits in OUT_W bits, which holds for IN_W <= 42 with 8.4 output.
module mag2db_scale #(
    parameter int LOG_W  = 17,
    parameter int LOG_FB = 12,
    parameter int K_FB   = 16,
    parameter int OUT_W  = 12,
    parameter int OUT_FB = 4,
    localparam longint unsigned K_VAL = mag2db_pkg::db_per_octave(K_FB),
    localparam int K_W    = K_FB + 3,
    localparam int PROD_W = LOG_W + K_W,
    localparam int SH     = LOG_FB + K_FB - OUT_FB
) (
    input  logic [LOG_W-1:0] log2_val,
    output logic [OUT_W-1:0] db
);
    localparam logic [K_W-1:0]    K_CONST = K_W'(K_VAL);
    localparam logic [PROD_W-1:0] HALF    = PROD_W'(1) << (SH - 1);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] rounded;

    // Product, then add half an output LSB and drop the extra fraction bits.
    always_comb begin
        prod    = PROD_W'(log2_val) * PROD_W'(K_CONST);
        rounded = (prod + HALF) >> SH;
        db      = rounded[OUT_W-1:0];
    end
endmodule

// File: rtl/mag2db.sv
// Module: streaming amplitude-to-decibel converter, top level.
// Stage 1 registers the leading-one position and table index. Stage 2 registers
// log2 = {position, table fraction}. Stage 3 registers the scaled, rounded dB
// value. Latency is 3 cycles and one sample is accepted per clock. A zero input
// gives 0 dB plus a flag. Outputs hold between valid samples.
// Synchronous active-low reset.
module mag2db #(
    parameter int IN_W   = 24,
    parameter int ABITS  = 8,
    parameter int TBL_FB = 12,
    parameter int K_FB   = 16,
    parameter int OUT_W  = 12,
    parameter int OUT_FB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_mag,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_db,
    output logic             out_zero
);
    localparam int POS_W = $clog2(IN_W);
    localparam int LOG_W = POS_W + TBL_FB;

    // Stage 1 signals.
    logic [POS_W-1:0]  lod_pos;
    logic [ABITS-1:0]  lod_idx;
    logic              lod_zero;
    logic              s1_valid;
    logic [POS_W-1:0]  s1_pos;
    logic [ABITS-1:0]  s1_idx;
    logic              s1_zero;

    // Stage 2 signals.
    logic [TBL_FB-1:0] rom_frac;
    logic              s2_valid;
    logic [LOG_W-1:0]  s2_log;
    logic              s2_zero;

    // Stage 3 input.
    logic [OUT_W-1:0]  scaled_db;

    mag2db_lod #(.IN_W(IN_W), .ABITS(ABITS)) i_lod (
        .mag  (in_mag),
        .pos  (lod_pos),
        .idx  (lod_idx),
        .zero (lod_zero)
    );

    // Stage 1: capture the normalisation result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_pos   <= '0;
            s1_idx   <= '0;
            s1_zero  <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_pos  <= lod_pos;
                s1_idx  <= lod_idx;
                s1_zero <= lod_zero;
            end
        end
    end

    mag2db_frac_rom #(.ABITS(ABITS), .FBITS(TBL_FB)) i_rom (
        .addr (s1_idx),
        .frac (rom_frac)
    );

    // Stage 2: join the integer and fractional log2; force zero for an empty input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_log   <= '0;
            s2_zero  <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_log  <= s1_zero ? '0 : {s1_pos, rom_frac};
                s2_zero <= s1_zero;
            end
        end
    end

    mag2db_scale #(
        .LOG_W(LOG_W), .LOG_FB(TBL_FB), .K_FB(K_FB),
        .OUT_W(OUT_W), .OUT_FB(OUT_FB)
    ) i_scale (
        .log2_val (s2_log),
        .db       (scaled_db)
    );

    // Stage 3: output registers, updated only for a valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_db    <= '0;
            out_zero  <= 1'b0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                out_db   <= s2_zero ? '0 : scaled_db;
                out_zero <= s2_zero;
            end
        end
    end
endmodule

// File: rtl/mag2db_chk.sv
// Checker: temporal properties of the converter's ports, attached by bind.
module mag2db_chk #(
    parameter int IN_W  = 24,
    parameter int OUT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_mag,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_db,
    input logic             out_zero
);
    localparam int DB_MAX = $rtoi(real'(IN_W) * 6.020599913279624 * 16.0) + 1;

    logic [1:0] since_rst;

    // Count cycles since reset, saturating at 3, to bound the look-back.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_LATENCY_3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R5

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(in_valid, 3)) |->
            (out_zero == ($past(in_mag, 3) == '0))); // R4

    AST_ZERO_DB: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_zero) |-> (out_db == '0)); // R4

    AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_db) <= DB_MAX)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !out_valid) |-> ($stable(out_db) && $stable(out_zero))); // R6

    AST_EARLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd3) |-> (!out_valid && out_db == '0 && !out_zero)); // R8
endmodule

bind mag2db mag2db_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) i_mag2db_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mag    (in_mag),
    .out_valid (out_valid),
    .out_db    (out_db),
    .out_zero  (out_zero)
);

// File: tb/test_mag2db.sv
// Bench: a behavioural reference tracks the last three driven samples and
// compares the outputs on every clock against real-arithmetic 20*log10.
module test_mag2db;
    localparam int IN_W  = 24;
    localparam int OUT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_mag = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_db;
    logic             out_zero;

    int n_checks = 0;
    int n_fail   = 0;
    bit running  = 1'b0;
    bit done     = 1'b0;

    // Reference history: index 0 = most recently driven.
    bit          h_v [3];
    int unsigned h_m [3];
    int          last_db   = 0;
    bit          last_zero = 1'b0;
    int unsigned seed      = 32'h1234_5677;

    always #4 clk = ~clk;   // 125 MHz

    mag2db i_mag2db (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mag(in_mag),
        .out_valid(out_valid), .out_db(out_db), .out_zero(out_zero)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int unsigned m);
        if (m == 0)                 return "R4";
        if (m == 1)                 return "R2";
        if (m == 32'h80_0000)       return "R3";
        if (m == 32'hFF_FFFF)       return "R7";
        return "R1";
    endfunction

    // One clock: compare outputs for the sample driven three negedges ago, then drive.
    task automatic step(input bit v, input int unsigned m);
        @(negedge clk);
        check(out_valid == h_v[2], "R5", "out_valid", int'(out_valid), int'(h_v[2]));
        if (h_v[2]) begin
            if (h_m[2] == 0) begin
                check(out_db == 0 && out_zero, "R4", "zero input db/flag",
                      int'(out_db) + 10000 * int'(out_zero), 10000);
            end else begin
                real ideal;
                real diff;
                ideal = 20.0 * $log10(real'(h_m[2])) * 16.0;
                diff  = real'(out_db) - ideal;
                check(diff <= 1.0 && diff >= -1.0 && !out_zero, req_of(h_m[2]),
                      $sformatf("db for %0d", h_m[2]), int'(out_db), $rtoi(ideal + 0.5));
                if (h_m[2] == 1)
                    check(out_db == 0, "R2", "unit input", int'(out_db), 0);
                if (h_m[2] == 32'h80_0000)
                    check(out_db == 2215 || out_db == 2216, "R3", "2^23 input", int'(out_db), 2216);
                if (h_m[2] == 32'hFF_FFFF)
                    check(out_db <= 2312, "R7", "full scale bound", int'(out_db), 2312);
            end
            last_db   = int'(out_db);
            last_zero = out_zero;
        end else begin
            check(int'(out_db) == last_db && out_zero == last_zero, "R6", "hold while idle",
                  int'(out_db), last_db);
        end
        h_v[2] = h_v[1]; h_m[2] = h_m[1];
        h_v[1] = h_v[0]; h_m[1] = h_m[0];
        h_v[0] = v;      h_m[0] = m;
        in_valid = v;
        in_mag   = IN_W'(m);
    endtask

    function automatic int unsigned next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Watchdog.
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R5 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin h_v[i] = 1'b0; h_m[i] = 0; end
        repeat (4) @(negedge clk);
        check(!out_valid && out_db == 0 && !out_zero, "R8", "reset state",
              int'(out_valid) + int'(out_db) + int'(out_zero), 0);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        // Directed corners, including back-to-back samples.
        step(1'b1, 1);
        step(1'b1, 32'h80_0000);
        step(1'b1, 0);
        step(1'b1, 32'hFF_FFFF);
        step(1'b0, 0);
        step(1'b0, 0);
        step(1'b1, 0);
        step(1'b0, 5);
        step(1'b0, 0);
        step(1'b0, 0);
        // Powers of two and their neighbours.
        for (int k = 0; k < IN_W; k++) begin
            step(1'b1, 32'd1 << k);
            if (k > 0) step(1'b1, (32'd1 << k) - 1);
            if (k > 1) step(1'b1, (32'd1 << k) + 1);
        end
        // Pseudo-random sweep over the dynamic range, with idle gaps.
        for (int n = 0; n < 6000; n++) begin
            int unsigned r;
            int unsigned s;
            r = next_rand();
            s = next_rand() % 24;
            step((r & 32'h7) != 0, (r & 32'hFF_FFFF) >> s);
        end
        // Every table index under one exponent.
        for (int j = 0; j < 512; j++) step(1'b1, 32'h20_0000 + (j << 12));
        repeat (4) step(1'b0, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule